// File: doc/BRIEF.md
# Parallel TFT Panel Init and Pixel Streaming Controller

This block drives a small TFT panel controller over a 16-bit parallel write bus. The bus has active-low chip select, register select, write strobe, read strobe and panel reset lines, plus a backlight enable. Once the active-low power-on reset is released, the block holds the panel in reset for a set time and then waits a recovery time. It then plays a fixed register-initialisation table that sets up a 16-bit RGB565 pixel format and a full-screen window for the configured resolution (320x240 by default).

When the table has been written, the block raises a sticky done flag, so that a downstream block such as a camera configurator can start its own setup. From then on it stays in write mode. Each rising edge of the incoming vertical sync makes it set the display-memory address back to the origin and open a memory-write burst. Every pixel that arrives with its valid strobe while the horizontal sync is high then becomes one data write to the panel.

Top module: `tft_stream_ctrl`

## Requirements
- R1: While `por_n` is low, `lcd_cs_n`, `lcd_wr_n` and `lcd_rd_n` are high, `lcd_rst_n` is low, and `init_done` and `lcd_bl_en` are low.
- R2: After `por_n` goes high, `lcd_rst_n` stays low for exactly RST_CYC clock cycles. No write strobe falls until at least RST_CYC further cycles have passed, and no strobe occurs while `lcd_rst_n` is low.
- R3: Every bus write holds `lcd_wr_n` low for WR_LOW clocks (at least 2) and then high for WR_HIGH clocks. `lcd_cs_n` is low whenever `lcd_wr_n` is low, and `lcd_data`/`lcd_rs` are stable while `lcd_wr_n` is low.
- R4: A register write is an index cycle with `lcd_rs`=0 followed by a data cycle with `lcd_rs`=1. The init table writes, in order: 0x0001←0x0100, 0x0003←0x1030 (selects 16-bit RGB565), 0x0050←0, 0x0051←H_RES-1, 0x0052←0, 0x0053←V_RES-1, 0x0007←0x0133.
- R5: `init_done` rises only after the last init write cycle has finished, never falls before the next reset, and `lcd_bl_en` turns on with it.
- R6: On each rising edge of `vsync_in` after init, the block writes 0x0020←0x0000 and 0x0021←0x0000, then the index 0x0022 (RS=0), before any pixel.
- R7: In streaming mode, each `pix_valid` pulse with `href_in` high produces one RS=1 write carrying `pix_data`, in arrival order.
- R8: A pixel is dropped, with no bus write, if it arrives before the first vsync, with `href_in` low, during the address sequence, or while the previous write cycle is still in progress.
- R9: A `vsync_in` rising edge during streaming restarts the address sequence of R6.
- R10: `lcd_rd_n` is never driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Active-low power-on reset, synchronous |
| vsync_in | input | 1 | Frame sync from the pixel pipeline |
| href_in | input | 1 | Line-valid sync from the pixel pipeline |
| pix_valid | input | 1 | One-cycle strobe: `pix_data` holds a pixel |
| pix_data | input | 16 | RGB565 pixel |
| lcd_data | output | 16 | Panel data bus |
| lcd_cs_n | output | 1 | Panel chip select, active low |
| lcd_rs | output | 1 | Register select: 0 index, 1 data |
| lcd_wr_n | output | 1 | Write strobe, active low, latched on rising edge |
| lcd_rd_n | output | 1 | Read strobe, held inactive |
| lcd_rst_n | output | 1 | Panel reset, active low |
| lcd_bl_en | output | 1 | Backlight enable |
| init_done | output | 1 | Sticky: panel configuration complete |

## Verification
The hardest situations to reach from the ports are pixels that must be dropped: one that lands inside the address sequence started by a vsync, and one that arrives one clock after an accepted pixel while the write cycle is still busy. The stimulus raises vsync and sends a pixel three clocks later, so that it falls inside the address writes. It also sends two pixel strobes on consecutive clocks. A panel monitor logs every strobe rising edge, and the log length and contents show which pixels were written. A second vsync in the middle of streaming covers the restart path.

// File: rtl/tft_pkg.sv
package tft_pkg;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_INIT,
    ST_IDLE,
    ST_FRAME,
    ST_STREAM
  } ctl_state_t;

  typedef struct packed {
    logic        rs;
    logic [15:0] val;
  } bus_word_t;

  localparam int INIT_WORDS  = 14;
  localparam int FRAME_WORDS = 5;

  // Even step: register index (rs=0); odd step: register value (rs=1)
  function automatic bus_word_t init_word(int step, int hres, int vres);
    logic [15:0] reg_idx;
    logic [15:0] reg_val;
    bus_word_t   w;
    case (step / 2)
      0:       begin reg_idx = 16'h0001; reg_val = 16'h0100;           end
      1:       begin reg_idx = 16'h0003; reg_val = 16'h1030;           end
      2:       begin reg_idx = 16'h0050; reg_val = 16'h0000;           end
      3:       begin reg_idx = 16'h0051; reg_val = 16'(hres - 1);      end
      4:       begin reg_idx = 16'h0052; reg_val = 16'h0000;           end
      default: begin
        if (step / 2 == 5) begin reg_idx = 16'h0053; reg_val = 16'(vres - 1); end
        else               begin reg_idx = 16'h0007; reg_val = 16'h0133;      end
      end
    endcase
    w.rs  = step[0];
    w.val = step[0] ? reg_val : reg_idx;
    return w;
  endfunction

  // Origin address then memory-write index
  function automatic bus_word_t frame_word(int step);
    bus_word_t w;
    case (step)
      0:       w = '{rs: 1'b0, val: 16'h0020};
      1:       w = '{rs: 1'b1, val: 16'h0000};
      2:       w = '{rs: 1'b0, val: 16'h0021};
      3:       w = '{rs: 1'b1, val: 16'h0000};
      default: w = '{rs: 1'b0, val: 16'h0022};
    endcase
    return w;
  endfunction

endpackage

// File: rtl/tft_reset_timer.sv
module tft_reset_timer #(
  parameter int RST_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic panel_rst_n,
  output logic ready
);
  localparam int TW = $clog2(RST_CYC + 1);

  logic          released;
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      released <= 1'b0;
      ready    <= 1'b0;
      cnt      <= '0;
    end else if (!ready) begin
      if (cnt == TW'(RST_CYC - 1)) begin
        cnt <= '0;
        if (released) ready <= 1'b1;
        else          released <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign panel_rst_n = released;

  // R2: ready only after the reset line has been released
  p_ready_after_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(panel_rst_n));

endmodule

// File: rtl/tft_wr_engine.sv
module tft_wr_engine
  import tft_pkg::*;
#(
  parameter int WR_LOW  = 2,
  parameter int WR_HIGH = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  bus_word_t   word_in,
  output logic        busy,
  output logic        done,
  output logic        cs_n,
  output logic        wr_n,
  output logic        rs,
  output logic [15:0] data
);
  localparam int CYC = WR_LOW + WR_HIGH;
  localparam int CW  = $clog2(CYC + 1);

  logic [CW-1:0] cnt;
  bus_word_t     word_q;

  assign done = busy && (cnt == CW'(CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      word_q <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      cnt    <= '0;
      word_q <= word_in;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign cs_n = !busy;
  assign wr_n = !(busy && (cnt < CW'(WR_LOW)));
  assign rs   = word_q.rs;
  assign data = word_q.val;

  p_cs_with_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> !cs_n);
  p_wr_min_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |=> !wr_n);
  p_data_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && $past(!wr_n)) |-> ($stable(data) && $stable(rs)));
  p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |-> !start);

endmodule

// File: rtl/tft_stream_ctrl.sv
module tft_stream_ctrl
  import tft_pkg::*;
#(
  parameter int H_RES   = 320,
  parameter int V_RES   = 240,
  parameter int RST_CYC = 16,
  parameter int WR_LOW  = 2,
  parameter int WR_HIGH = 2
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        vsync_in,
  input  logic        href_in,
  input  logic        pix_valid,
  input  logic [15:0] pix_data,
  output logic [15:0] lcd_data,
  output logic        lcd_cs_n,
  output logic        lcd_rs,
  output logic        lcd_wr_n,
  output logic        lcd_rd_n,
  output logic        lcd_rst_n,
  output logic        lcd_bl_en,
  output logic        init_done
);
  localparam int SW = $clog2(INIT_WORDS + 1);

  ctl_state_t    st;
  logic [SW-1:0] step;
  logic          vs_q, vs_pend, done_q;
  logic          tmr_ready;
  logic          eng_busy, eng_done, eng_free, eng_start;
  bus_word_t     eng_word;

  // Named internal events
  logic vs_rise, pix_take, init_last, frame_last;

  tft_reset_timer #(.RST_CYC(RST_CYC)) u_rst (
    .clk(clk), .rst_n(por_n), .panel_rst_n(lcd_rst_n), .ready(tmr_ready)
  );

  tft_wr_engine #(.WR_LOW(WR_LOW), .WR_HIGH(WR_HIGH)) u_eng (
    .clk(clk), .rst_n(por_n), .start(eng_start), .word_in(eng_word),
    .busy(eng_busy), .done(eng_done), .cs_n(lcd_cs_n), .wr_n(lcd_wr_n),
    .rs(lcd_rs), .data(lcd_data)
  );

  assign eng_free   = !eng_busy || eng_done;
  assign vs_rise    = vsync_in && !vs_q;
  assign init_last  = (st == ST_INIT)  && (step == SW'(INIT_WORDS));
  assign frame_last = (st == ST_FRAME) && (step == SW'(FRAME_WORDS));
  assign pix_take   = (st == ST_STREAM) && !vs_pend && eng_free && pix_valid && href_in;

  always_comb begin
    eng_start = 1'b0;
    eng_word  = '0;
    case (st)
      ST_INIT: if (eng_free && !init_last) begin
        eng_start = 1'b1;
        eng_word  = init_word(int'(step), H_RES, V_RES);
      end
      ST_FRAME: if (eng_free && !frame_last) begin
        eng_start = 1'b1;
        eng_word  = frame_word(int'(step));
      end
      ST_STREAM: if (pix_take) begin
        eng_start = 1'b1;
        eng_word  = '{rs: 1'b1, val: pix_data};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!por_n) begin
      st      <= ST_WAIT;
      step    <= '0;
      vs_q    <= 1'b0;
      vs_pend <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      vs_q <= vsync_in;
      case (st)
        ST_WAIT: if (tmr_ready) begin
          st   <= ST_INIT;
          step <= '0;
        end
        ST_INIT: if (eng_free) begin
          if (init_last) begin
            st     <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            step <= step + 1'b1;
          end
        end
        ST_FRAME: if (eng_free) begin
          if (frame_last) st <= ST_STREAM;
          else            step <= step + 1'b1;
        end
        default: if (vs_pend && eng_free) begin
          st      <= ST_FRAME;
          step    <= '0;
          vs_pend <= 1'b0;
        end
      endcase
      if (vs_rise && done_q) vs_pend <= 1'b1;
    end
  end

  assign init_done = done_q;
  assign lcd_bl_en = done_q;
  assign lcd_rd_n  = 1'b1;

  p_quiet_in_reset_r2: assert property (@(posedge clk) disable iff (!por_n)
    !lcd_rst_n |-> (lcd_cs_n && lcd_wr_n));
  p_done_sticky_r5: assert property (@(posedge clk) disable iff (!por_n)
    init_done |=> init_done);
  p_done_after_bus_r5: assert property (@(posedge clk) disable iff (!por_n)
    $rose(init_done) |-> $past(eng_done));
  p_pixel_only_streaming_r8: assert property (@(posedge clk) disable iff (!por_n)
    (eng_start && st != ST_INIT) |-> done_q);

endmodule

// File: tb/tb_tft_stream_ctrl.sv
module tb_tft_stream_ctrl;

  localparam int RST_CYC = 16;
  localparam int WR_LOW  = 2;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        vsync_in = 1'b0, href_in = 1'b0, pix_valid = 1'b0;
  logic [15:0] pix_data = '0;
  logic [15:0] lcd_data;
  logic        lcd_cs_n, lcd_rs, lcd_wr_n, lcd_rd_n, lcd_rst_n, lcd_bl_en, init_done;

  always #10 clk = ~clk;

  tft_stream_ctrl dut (
    .clk(clk), .por_n(por_n), .vsync_in(vsync_in), .href_in(href_in),
    .pix_valid(pix_valid), .pix_data(pix_data), .lcd_data(lcd_data),
    .lcd_cs_n(lcd_cs_n), .lcd_rs(lcd_rs), .lcd_wr_n(lcd_wr_n), .lcd_rd_n(lcd_rd_n),
    .lcd_rst_n(lcd_rst_n), .lcd_bl_en(lcd_bl_en), .init_done(init_done)
  );

  int checks = 0, errors = 0;
  bit fin = 0;

  // Panel model: log {rs,data} on each strobe rising edge
  logic [16:0] wlog [0:255];
  int nlog = 0;
  always @(posedge lcd_wr_n) if (por_n === 1'b1 && lcd_cs_n === 1'b0) begin
    wlog[nlog] = {lcd_rs, lcd_data};
    nlog++;
  end

  int run = 0, wid_bad = 0, cs_bad = 0, rd_bad = 0, wr_in_rst = 0;
  always @(negedge clk) if (por_n) begin
    if (!lcd_rd_n) rd_bad++;
    if (!lcd_wr_n) begin
      run++;
      if (lcd_cs_n) cs_bad++;
      if (!lcd_rst_n) wr_in_rst++;
    end else if (run != 0) begin
      if (run != WR_LOW) wid_bad++;
      run = 0;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_word(int idx, logic [16:0] exp, string req);
    chk(idx < nlog && wlog[idx] == exp, req, $sformatf("write %0d", idx),
        (idx < nlog) ? int'(wlog[idx]) : -1, int'(exp));
  endtask

  task automatic send_pix(logic [15:0] d, bit href);
    @(negedge clk);
    href_in = href; pix_valid = 1'b1; pix_data = d;
    @(negedge clk);
    pix_valid = 1'b0; href_in = 1'b0;
  endtask

  task automatic pulse_vsync();
    @(negedge clk); vsync_in = 1'b1;
    repeat (3) @(negedge clk);
    vsync_in = 1'b0;
  endtask

  // Expected init writes, built from R4 (H_RES=320, V_RES=240)
  logic [16:0] exp_init [14];
  initial begin
    logic [15:0] regs [7] = '{16'h0001, 16'h0003, 16'h0050, 16'h0051, 16'h0052, 16'h0053, 16'h0007};
    logic [15:0] vals [7] = '{16'h0100, 16'h1030, 16'h0000, 16'd319, 16'h0000, 16'd239, 16'h0133};
    for (int i = 0; i < 7; i++) begin
      exp_init[2*i]   = {1'b0, regs[i]};
      exp_init[2*i+1] = {1'b1, vals[i]};
    end
  end

  localparam logic [15:0] PIX_TAB [8] = '{16'hF800, 16'h07E0, 16'h001F, 16'hFFFF,
                                          16'h0000, 16'hA5A5, 16'h5A5A, 16'h1234};

  task automatic chk_frame(int base, string req);
    chk_word(base,     {1'b0, 16'h0020}, req);
    chk_word(base + 1, {1'b1, 16'h0000}, req);
    chk_word(base + 2, {1'b0, 16'h0021}, req);
    chk_word(base + 3, {1'b1, 16'h0000}, req);
    chk_word(base + 4, {1'b0, 16'h0022}, req);
  endtask

  initial begin
    int low_cnt, gap, base;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(lcd_cs_n && lcd_wr_n && lcd_rd_n && !lcd_rst_n && !init_done && !lcd_bl_en,
        "R1", "reset outputs", {lcd_cs_n, lcd_wr_n, lcd_rd_n, lcd_rst_n, init_done, lcd_bl_en}, 6'b111000);

    // R2: panel reset width and recovery
    por_n = 1'b1;
    low_cnt = 0;
    while (!lcd_rst_n && low_cnt < 1000) begin low_cnt++; @(negedge clk); end
    chk(low_cnt == RST_CYC, "R2", "reset low cycles", low_cnt, RST_CYC);
    gap = 0;
    while (lcd_wr_n && gap < 1000) begin gap++; @(negedge clk); end
    chk(gap >= RST_CYC, "R2", "recovery before first write", gap, RST_CYC);

    // R4/R5: init sequence and done
    wait (nlog == 14);
    #1;
    chk(!init_done, "R5", "done before last cycle ends", init_done, 0);
    wait (init_done);
    @(negedge clk);
    chk(lcd_bl_en, "R5", "backlight with done", lcd_bl_en, 1);
    for (int i = 0; i < 14; i++) chk_word(i, exp_init[i], "R4");

    // R8: pixel before first vsync ignored
    send_pix(16'hBEEF, 1'b1);
    repeat (6) @(negedge clk);
    chk(nlog == 14, "R8", "pixel before vsync", nlog, 14);

    // R6/R8: vsync, pixel during address sequence dropped
    pulse_vsync();
    send_pix(16'hDEAD, 1'b1);
    repeat (30) @(negedge clk);
    chk(nlog == 19, "R8", "pixel during address seq", nlog, 19);
    chk_frame(14, "R6");

    // R7: stimulus table walk
    base = nlog;
    for (int i = 0; i < 8; i++) begin
      send_pix(PIX_TAB[i], 1'b1);
      repeat (5) @(negedge clk);
    end
    for (int i = 0; i < 8; i++) chk_word(base + i, {1'b1, PIX_TAB[i]}, "R7");

    // R8: href low ignored
    base = nlog;
    send_pix(16'h4444, 1'b0);
    repeat (6) @(negedge clk);
    chk(nlog == base, "R8", "href low pixel", nlog, base);

    // R8: second pixel while busy dropped
    @(negedge clk);
    href_in = 1'b1; pix_valid = 1'b1; pix_data = 16'h1111;
    @(negedge clk);
    pix_data = 16'h2222;
    @(negedge clk);
    pix_valid = 1'b0; href_in = 1'b0;
    repeat (8) @(negedge clk);
    chk(nlog == base + 1, "R8", "back-to-back pixel", nlog, base + 1);
    chk_word(base, {1'b1, 16'h1111}, "R8");

    // R9: vsync during streaming restarts address sequence
    base = nlog;
    pulse_vsync();
    repeat (30) @(negedge clk);
    chk(nlog == base + 5, "R9", "restart write count", nlog, base + 5);
    chk_frame(base, "R9");
    send_pix(16'hCAFE, 1'b1);
    repeat (6) @(negedge clk);
    chk_word(base + 5, {1'b1, 16'hCAFE}, "R9");

    // R3 and R10: bus timing monitors
    chk(wid_bad == 0, "R3", "strobe width errors", wid_bad, 0);
    chk(cs_bad == 0, "R3", "strobe without select", cs_bad, 0);
    chk(wr_in_rst == 0, "R2", "strobe during panel reset", wr_in_rst, 0);
    chk(rd_bad == 0, "R10", "read strobe low", rd_bad, 0);
    chk(init_done, "R5", "done still high", init_done, 1);

    fin = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule